// File: doc/BRIEF.md
# Transmit Frame Enqueue Sequencer

This block pushes one outgoing frame into a transmit queue that sits behind an indirect register bus 16 bits wide. On a start request it latches the frame byte length and drives a fixed series of bus transactions. It reads the free-space register and decides whether the frame fits. If it does, it turns on streaming data-port access with pointer auto-increment and writes a two-word header. It then writes the payload words, which come from a valid/ready stream. Last, it turns streaming access off, commits the frame and polls the commit bit until the queue clears it.

Each bus transaction is a request that stays asserted, with stable fields, until the bus returns a one-cycle acknowledge. A read returns its data on `bus_rdata` in the acknowledge cycle. The run ends with a one-cycle `done` pulse. The code on `done_status` is 0 when the frame was committed, 1 when there was not enough space, and 2 when the commit poll ran out.

Top module: `txq_enqueue_seq`

## Requirements
- R1: After reset `bus_req`, `s_ready` and `done` are low, and they stay low until a start is accepted.
- R2: A start is accepted only while the block is idle, and a start during a run has no effect on that run's transactions. The first transaction of every run is a 16-bit read (`bus_be`=2'b11) of register address FREE_ADDR.
- R3: The free value is `bus_rdata & 16'h1FFF`. When it is below frame length + 12, the run ends with status 1 and no further transaction. A value equal to length + 12 proceeds.
- R4: After the free read, the block writes AUTOINC_VAL to PTR_ADDR with be 2'b11. It then writes to RXQ_ADDR with be 2'b01, data[7:0] = cached control | STREAM_BIT and data[15:8] = 0.
- R5: Two data-port writes (`bus_data_port`=1, `bus_addr`=0, be 2'b11) form the header: first 16'h0000, then the length, with the low byte in bits [7:0].
- R6: Payload: ceil(len/4)*2 data-port writes. The first ceil(len/2) carry stream words in arrival order and the rest are 16'h0000. Exactly ceil(len/2) stream handshakes take place.
- R7: After the payload, the block writes RXQ_ADDR with be 2'b01 and data[7:0] = cached control with STREAM_BIT cleared, data[15:8] = 0.
- R8: It then writes COMMIT_BIT to TXQ_ADDR and reads TXQ_ADDR until (`bus_rdata` & COMMIT_BIT) is 0. The run then ends with status 0.
- R9: If POLL_LIMIT consecutive polls all read the commit bit set, the run ends with status 2 after exactly POLL_LIMIT reads.
- R10: `done` is high for exactly one cycle per run. While `bus_req` waits for `bus_ack`, all request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a frame (taken when idle) |
| frame_len | input | LEN_W | Frame length in bytes |
| rxq_ctl_cache | input | 8 | Cached low byte of the receive-queue control register |
| s_valid | input | 1 | Payload word valid |
| s_data | input | 16 | Payload word, lower byte first in frame order |
| s_ready | output | 1 | Payload word accepted |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_data_port | output | 1 | 1 = data-port access, 0 = register access |
| bus_addr | output | ADDR_W | Register address (0 for data port) |
| bus_be | output | 2 | Byte enables of the 16-bit word |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle end-of-run pulse |
| done_status | output | 2 | 0 ok, 1 no space, 2 poll timeout |

## Verification
The hardest case to reach is the path that ends in a poll timeout. It needs a queue that keeps the commit bit set through every allowed poll, which real hardware almost never does. The bench's bus model is told, per frame, how many polls to answer busy. With a small poll limit it runs one frame just below the limit and one exactly at it. The free-space register is answered with junk in its top three bits, so the masked comparison is exercised at exact-fit and one-byte-short boundaries. A stalling payload stream and a stray start pulse sent in the middle of a run stress the handshake and idle-only acceptance.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_FREE,
    SQ_PTR,
    SQ_SON,
    SQ_HDR0,
    SQ_HDR1,
    SQ_PAY,
    SQ_SOFF,
    SQ_COMMIT,
    SQ_POLL
  } sq_state_e;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_NOSPACE = 2'd1;
  localparam logic [1:0] ST_TIMEOUT = 2'd2;

  localparam logic [15:0] FREE_MASK = 16'h1FFF;
  localparam int unsigned FRAME_OVERHEAD = 12;

  // Masked free count must cover the frame plus the fixed overhead.
  function automatic logic room_ok(input logic [15:0] raw, input logic [15:0] len);
    logic [16:0] avail;
    logic [16:0] need;
    avail = {1'b0, raw & FREE_MASK};
    need  = {1'b0, len} + 17'(FRAME_OVERHEAD);
    return avail >= need;
  endfunction

endpackage

// File: rtl/txq_word_feeder.sv
module txq_word_feeder #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             en,
  input  logic             advance,
  input  logic             s_valid,
  input  logic [15:0]      s_data,
  output logic             s_ready,
  output logic [15:0]      word,
  output logic             word_ok,
  output logic             last_word,
  output logic             none
);

  localparam int LW1 = LEN_W + 1;

  // Bus words: byte count rounded up to a multiple of four, in 16-bit units.
  function automatic logic [LW1-1:0] bus_words(input logic [LEN_W-1:0] n);
    logic [LW1-1:0] e;
    e = {1'b0, n} + LW1'(3);
    return {e[LW1-1:2], 1'b0};
  endfunction

  // Stream words: byte count rounded up to an even number, in 16-bit units.
  function automatic logic [LW1-1:0] src_words(input logic [LEN_W-1:0] n);
    logic [LW1-1:0] e;
    e = {1'b0, n} + LW1'(1);
    return {1'b0, e[LW1-1:1]};
  endfunction

  logic [LW1-1:0] idx_q, tot_q, src_q;
  logic           held_q;
  logic [15:0]    hold_q;
  logic           take;
  logic           from_stream;

  assign from_stream = idx_q < src_q;
  assign s_ready     = en && !held_q && from_stream;
  assign take        = s_ready && s_valid;
  assign word_ok     = held_q || !from_stream;
  assign word        = held_q ? hold_q : 16'h0000;
  assign last_word   = idx_q == (tot_q - LW1'(1));
  assign none        = tot_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      tot_q  <= '0;
      src_q  <= '0;
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (load) begin
      idx_q  <= '0;
      tot_q  <= bus_words(len);
      src_q  <= src_words(len);
      held_q <= 1'b0;
    end else if (advance) begin
      idx_q  <= idx_q + LW1'(1);
      held_q <= 1'b0;
    end else if (take) begin
      held_q <= 1'b1;
      hold_q <= s_data;
    end
  end

endmodule

// File: rtl/txq_poll_limiter.sv
module txq_poll_limiter #(
  parameter int POLL_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expire
);

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt_q;

  // Asserted while the poll in flight is the last one allowed.
  assign expire = cnt_q == CW'(POLL_LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/txq_enqueue_seq.sv
module txq_enqueue_seq
  import txq_pkg::*;
#(
  parameter int          LEN_W       = 11,
  parameter int          ADDR_W      = 8,
  parameter int          POLL_LIMIT  = 1024,
  parameter logic [7:0]  FREE_ADDR   = 8'h30,
  parameter logic [7:0]  PTR_ADDR    = 8'h32,
  parameter logic [7:0]  RXQ_ADDR    = 8'h34,
  parameter logic [7:0]  TXQ_ADDR    = 8'h36,
  parameter logic [15:0] AUTOINC_VAL = 16'h4000,
  parameter logic [7:0]  STREAM_BIT  = 8'h08,
  parameter logic [15:0] COMMIT_BIT  = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [7:0]        rxq_ctl_cache,
  input  logic              s_valid,
  input  logic [15:0]       s_data,
  output logic              s_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_data_port,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic [15:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [15:0]       bus_rdata,
  output logic              done,
  output logic [1:0]        done_status
);

  localparam logic [1:0] BE_WORD = 2'b11;
  localparam logic [1:0] BE_LOW  = 2'b01;

  sq_state_e        state_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       cache_q;
  logic             done_q;
  logic [1:0]       status_q;

  // Named internal events, used by the checker.
  logic busy_w;
  logic load_w;
  logic free_ack_w;
  logic space_ok_w;
  logic pay_ack_w;
  logic poll_ack_w;
  logic commit_clear_w;
  logic timeout_w;
  logic poll_clr_w;
  logic poll_inc_w;

  logic [15:0] pay_word;
  logic        pay_ok;
  logic        pay_last;
  logic        pay_none;
  logic        poll_expire;

  assign busy_w         = state_q != SQ_IDLE;
  assign load_w         = start && !busy_w;
  assign free_ack_w     = (state_q == SQ_FREE) && bus_ack;
  assign space_ok_w     = room_ok(bus_rdata, 16'(len_q));
  assign pay_ack_w      = (state_q == SQ_PAY) && bus_ack;
  assign poll_ack_w     = (state_q == SQ_POLL) && bus_ack;
  assign commit_clear_w = poll_ack_w && ((bus_rdata & COMMIT_BIT) == 16'h0000);
  assign timeout_w      = poll_ack_w && !commit_clear_w && poll_expire;
  assign poll_clr_w     = (state_q == SQ_COMMIT) && bus_ack;
  assign poll_inc_w     = poll_ack_w && !commit_clear_w;

  txq_word_feeder #(.LEN_W(LEN_W)) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .len       (frame_len),
    .en        (state_q == SQ_PAY),
    .advance   (pay_ack_w),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .word      (pay_word),
    .word_ok   (pay_ok),
    .last_word (pay_last),
    .none      (pay_none)
  );

  txq_poll_limiter #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (poll_clr_w),
    .inc    (poll_inc_w),
    .expire (poll_expire)
  );

  // Bus request fields come straight from the state, so they hold until ack.
  always_comb begin
    bus_req       = 1'b0;
    bus_we        = 1'b0;
    bus_data_port = 1'b0;
    bus_addr      = '0;
    bus_be        = BE_WORD;
    bus_wdata     = 16'h0000;
    case (state_q)
      SQ_FREE: begin
        bus_req  = 1'b1;
        bus_addr = ADDR_W'(FREE_ADDR);
      end
      SQ_PTR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(PTR_ADDR);
        bus_wdata = AUTOINC_VAL;
      end
      SQ_SON: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(RXQ_ADDR);
        bus_be    = BE_LOW;
        bus_wdata = {8'h00, cache_q | STREAM_BIT};
      end
      SQ_HDR0: begin
        bus_req       = 1'b1;
        bus_we        = 1'b1;
        bus_data_port = 1'b1;
      end
      SQ_HDR1: begin
        bus_req       = 1'b1;
        bus_we        = 1'b1;
        bus_data_port = 1'b1;
        bus_wdata     = 16'(len_q);
      end
      SQ_PAY: begin
        bus_req       = pay_ok;
        bus_we        = 1'b1;
        bus_data_port = 1'b1;
        bus_wdata     = pay_word;
      end
      SQ_SOFF: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(RXQ_ADDR);
        bus_be    = BE_LOW;
        bus_wdata = {8'h00, cache_q & ~STREAM_BIT};
      end
      SQ_COMMIT: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(TXQ_ADDR);
        bus_wdata = COMMIT_BIT;
      end
      SQ_POLL: begin
        bus_req  = 1'b1;
        bus_addr = ADDR_W'(TXQ_ADDR);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      len_q    <= '0;
      cache_q  <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: if (start) begin
          len_q   <= frame_len;
          cache_q <= rxq_ctl_cache;
          state_q <= SQ_FREE;
        end
        SQ_FREE: if (bus_ack) begin
          if (space_ok_w) state_q <= SQ_PTR;
          else begin
            done_q   <= 1'b1;
            status_q <= ST_NOSPACE;
            state_q  <= SQ_IDLE;
          end
        end
        SQ_PTR:  if (bus_ack) state_q <= SQ_SON;
        SQ_SON:  if (bus_ack) state_q <= SQ_HDR0;
        SQ_HDR0: if (bus_ack) state_q <= SQ_HDR1;
        SQ_HDR1: if (bus_ack) state_q <= pay_none ? SQ_SOFF : SQ_PAY;
        SQ_PAY:  if (bus_ack && pay_last) state_q <= SQ_SOFF;
        SQ_SOFF: if (bus_ack) state_q <= SQ_COMMIT;
        SQ_COMMIT: if (bus_ack) state_q <= SQ_POLL;
        SQ_POLL: if (commit_clear_w) begin
          done_q   <= 1'b1;
          status_q <= ST_OK;
          state_q  <= SQ_IDLE;
        end else if (timeout_w) begin
          done_q   <= 1'b1;
          status_q <= ST_TIMEOUT;
          state_q  <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign done        = done_q;
  assign done_status = status_q;

endmodule

// File: rtl/txq_enqueue_chk.sv
module txq_enqueue_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic              bus_data_port,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_be,
  input logic [15:0]       bus_wdata,
  input logic              s_ready,
  input logic              done,
  input logic [1:0]        done_status,
  input logic              busy_w,
  input logic              free_ack_w,
  input logic              space_ok_w,
  input logic              commit_clear_w,
  input logic              timeout_w
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (!bus_req && !s_ready));

  // R3
  nospace_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_ack_w && !space_ok_w) |=> (done && done_status == 2'd1 && !bus_req));

  // R6
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !bus_req);

  // R8
  commit_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_clear_w |=> (done && done_status == 2'd0));

  // R9
  poll_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> (done && done_status == 2'd2 && !bus_req));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req &&
      $stable({bus_we, bus_data_port, bus_addr, bus_be, bus_wdata})));

endmodule

bind txq_enqueue_seq txq_enqueue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_req        (bus_req),
  .bus_ack        (bus_ack),
  .bus_we         (bus_we),
  .bus_data_port  (bus_data_port),
  .bus_addr       (bus_addr),
  .bus_be         (bus_be),
  .bus_wdata      (bus_wdata),
  .s_ready        (s_ready),
  .done           (done),
  .done_status    (done_status),
  .busy_w         (busy_w),
  .free_ack_w     (free_ack_w),
  .space_ok_w     (space_ok_w),
  .commit_clear_w (commit_clear_w),
  .timeout_w      (timeout_w)
);

// File: tb/tb_txq_enqueue_seq.sv
`timescale 1ns/1ps
module tb_txq_enqueue_seq;

  localparam int LEN_W = 11;
  localparam int LIMIT = 4;
  localparam int MAXE  = 1100;
  localparam logic [7:0]  A_FREE = 8'h30;
  localparam logic [7:0]  A_PTR  = 8'h32;
  localparam logic [7:0]  A_RXQ  = 8'h34;
  localparam logic [7:0]  A_TXQ  = 8'h36;
  localparam logic [15:0] V_AINC = 16'h4000;
  localparam logic [7:0]  V_STRM = 8'h08;
  localparam logic [15:0] V_CMT  = 16'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic [7:0] rxq_ctl_cache = 8'h00;
  logic s_valid = 1'b0;
  logic [15:0] s_data = 16'h0000;
  logic s_ready;
  logic bus_req, bus_we, bus_data_port;
  logic [7:0] bus_addr;
  logic [1:0] bus_be;
  logic [15:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [15:0] bus_rdata = 16'h0000;
  logic done;
  logic [1:0] done_status;

  always #2 clk = ~clk;

  txq_enqueue_seq #(.LEN_W(LEN_W), .POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .rxq_ctl_cache(rxq_ctl_cache), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_data_port(bus_data_port), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .done_status(done_status)
  );

  int tests = 0;
  int fails = 0;
  int seq = 0;

  // Bus model state
  logic [27:0] log_e [0:MAXE-1];
  int log_n = 0;
  logic [15:0] free_raw = 16'h0000;
  int busy_left = 0;

  // Stream source state
  int src_total = 0;
  int src_idx = 0;
  int stall_cnt = 0;
  bit taken = 0;

  function automatic logic [15:0] wordf(input int s, input int i);
    return 16'((s * 16'h0137) ^ (i * 16'h0A51) ^ 16'h3C00);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (frame %0d)", tag, act, exp, seq);
    end
  endtask

  // Bus responder: acks a request at a falling edge, drops the ack at the next.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req && rst_n) begin
        if (log_n < MAXE)
          log_e[log_n] = {bus_data_port, bus_we, bus_addr, bus_be,
                          bus_we ? bus_wdata : 16'h0000};
        log_n++;
        bus_rdata = 16'h0000;
        if (!bus_we && bus_addr == A_FREE) bus_rdata = free_raw;
        if (!bus_we && bus_addr == A_TXQ) begin
          if (busy_left > 0) begin
            bus_rdata = 16'hFFFF;
            busy_left--;
          end else bus_rdata = 16'hFFFE;
        end
        bus_ack = 1'b1;
      end
    end
  end

  // Payload source with periodic stalls.
  initial begin
    forever begin
      @(negedge clk);
      if (taken) src_idx++;
      stall_cnt++;
      s_valid = (src_idx < src_total) && (stall_cnt % 5 != 3);
      s_data  = wordf(seq, src_idx);
      taken   = s_valid && s_ready;
    end
  end

  task automatic run_frame(input int len, input logic [15:0] fr, input int busy,
                           input logic [7:0] cache, input bit poke);
    logic [27:0] exp [0:MAXE-1];
    string etag [0:MAXE-1];
    int n = 0;
    int nw, ns, st, wcnt, npoll;
    bit fits, seen, bad;
    logic [1:0] got;
    string ctag;
    seq++;
    fits = (int'(fr & 16'h1FFF) >= len + 12);
    nw = ((len + 3) / 4) * 2;
    ns = (len + 1) / 2;
    exp[n] = {1'b0, 1'b0, A_FREE, 2'b11, 16'h0000}; etag[n] = "R2"; n++;
    if (!fits) st = 1;
    else begin
      exp[n] = {1'b0, 1'b1, A_PTR, 2'b11, V_AINC}; etag[n] = "R4"; n++;
      exp[n] = {1'b0, 1'b1, A_RXQ, 2'b01, 8'h00, cache | V_STRM}; etag[n] = "R4"; n++;
      exp[n] = {1'b1, 1'b1, 8'h00, 2'b11, 16'h0000}; etag[n] = "R5"; n++;
      exp[n] = {1'b1, 1'b1, 8'h00, 2'b11, 16'(len)}; etag[n] = "R5"; n++;
      for (int i = 0; i < nw; i++) begin
        exp[n] = {1'b1, 1'b1, 8'h00, 2'b11, (i < ns) ? wordf(seq, i) : 16'h0000};
        etag[n] = "R6"; n++;
      end
      exp[n] = {1'b0, 1'b1, A_RXQ, 2'b01, 8'h00, cache & ~V_STRM}; etag[n] = "R7"; n++;
      exp[n] = {1'b0, 1'b1, A_TXQ, 2'b11, V_CMT}; etag[n] = "R8"; n++;
      npoll = (busy < LIMIT) ? busy + 1 : LIMIT;
      for (int i = 0; i < npoll; i++) begin
        exp[n] = {1'b0, 1'b0, A_TXQ, 2'b11, 16'h0000};
        etag[n] = (busy < LIMIT) ? "R8" : "R9"; n++;
      end
      st = (busy < LIMIT) ? 0 : 2;
    end
    // set up models while idle
    free_raw  = fr;
    busy_left = busy;
    src_idx   = 0;
    src_total = fits ? ns : 0;
    log_n     = 0;
    @(negedge clk);
    frame_len = LEN_W'(len);
    rxq_ctl_cache = cache;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    got = 2'd3;
    wcnt = 0;
    while (!seen && wcnt < 12000) begin
      if (done) begin
        seen = 1;
        got = done_status;
      end else begin
        @(negedge clk);
        wcnt++;
        if (poke && wcnt == 6) begin
          frame_len = LEN_W'(len + 40);
          start = 1'b1;
        end
        if (poke && wcnt == 7) start = 1'b0;
      end
    end
    start = 1'b0;
    if (!seen) begin
      tests++; fails++;
      $display("FAIL R10: no done within wait window, actual 0 expected 1 (frame %0d)", seq);
    end
    @(negedge clk);
    // R10: done lasts one cycle
    check(!done, "R10", 32'(done), 32'd0);
    repeat (6) @(negedge clk);
    ctag = (st == 1) ? "R3" : (st == 2) ? "R9" : "R8";
    check(got == 2'(st), ctag, 32'(got), 32'(st));
    check(log_n == n, poke ? "R2" : ctag, 32'(log_n), 32'(n));
    bad = 0;
    for (int i = 0; i < n && i < log_n; i++) begin
      if (!bad && log_e[i] !== exp[i]) begin
        bad = 1;
        check(0, etag[i], 32'(log_e[i]), 32'(exp[i]));
      end
    end
    if (!bad) check(1, "R2", 0, 0);
    check(src_idx == (fits ? ns : 0), "R6", 32'(src_idx), 32'(fits ? ns : 0));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during and after reset
    check(!bus_req, "R1", 32'(bus_req), 0);
    check(!s_ready, "R1", 32'(s_ready), 0);
    check(!done, "R1", 32'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!bus_req && !done, "R1", 32'({bus_req, done}), 0);
    // sweep of small lengths
    for (int l = 0; l <= 34; l++)
      run_frame(l, 16'hE000 | 16'(l + 12 + (l % 3)), l % LIMIT,
                (l % 2 == 1) ? 8'hA5 : 8'h5F, (l >= 8) && (l % 5 == 0));
    // R3 boundaries with junk in the masked bits
    run_frame(60, 16'h6000 | 16'd72, 1, 8'hC3, 1'b0);
    run_frame(60, 16'hE000 | 16'd71, 0, 8'hC3, 1'b0);
    run_frame(100, 16'h2000, 0, 8'h0F, 1'b0);
    run_frame(0, 16'd11, 0, 8'h0F, 1'b0);
    // R9 poll limit boundaries
    run_frame(1, 16'h1FFF, LIMIT - 1, 8'h08, 1'b0);
    run_frame(1, 16'h1FFF, LIMIT, 8'h08, 1'b0);
    run_frame(13, 16'h1FFF, LIMIT + 3, 8'hFF, 1'b1);
    // largest length
    run_frame(2047, 16'hFFFF, 2, 8'h3C, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule